// File: doc/BRIEF.md
# Global 64-bit Timer with Comparator

This block keeps a 64-bit free-running count and watches it with one 64-bit compare channel. Software reaches it through a simple 32-bit register bus: a write strobe, a byte address and write data, with read data returned combinationally for whatever address is presented. The count, the compare value and a 32-bit reload step are each accessed as 32-bit words. A match sets an interrupt status bit, and an interrupt line shows that bit when the enable bit is on. In repeat mode each match also adds the step to the compare value, so events recur with a fixed period and software does not touch the timer.

Every write to the count halves, the compare halves, the step or the control word is confirmed by a sticky acknowledge bit. Software polls that bit and clears it by writing 1. Two small state machines hold the control settings. The counter machine has the states CNT_HALT and CNT_COUNT. A control write whose bit 0 is 1 moves it from CNT_HALT to CNT_COUNT, and a control write whose bit 0 is 0 moves it back. The compare machine has four states. CMP_OFF means disabled. CMP_PARKED means disabled with reload preselected. CMP_SINGLE means enabled with no reload, and CMP_REPEAT means enabled with reload. Every control write loads this machine from control bits 2:1, so any state can go to any other, and it holds its state when there is no control write.

Top module: `gtimer64`

## Requirements
- R1: After reset every register reads 0 and irq is low.
- R2: In CNT_COUNT the 64-bit count (low word 0x00, high word 0x04) rises by one each clock, and the low word carries into the high word. In CNT_HALT the count holds.
- R3: A write to 0x00 or 0x04 replaces that half of the count, and the count does not advance on that clock.
- R4: The control word at 0x18 reads back bit 0 as run, bit 1 as compare enable and bit 2 as reload enable, as last written.
- R5: When the compare is enabled and the count equals the compare value (low 0x0C, high 0x10), bit 0 of the status word at 0x20 reads 1 from the next clock.
- R6: irq is high exactly when status bit 0 and enable bit 0 at 0x1C are both 1.
- R7: Writing 1 to bit 0 of 0x20 clears the status bit. A match on the same clock wins, and the bit stays 1.
- R8: In repeat mode each match adds the step at 0x14, zero-extended, to the compare value. A bus write to either compare half on the match clock replaces that half, and no step is added.
- R9: The acknowledge word at 0x24 has bit 0 for the compare low write, bit 1 for the compare high write, bit 2 for the step write and bit 16 for the control write. A bit becomes 1 one clock after its register changes and stays 1 until 1 is written to it. A new acknowledge beats a clear on the same clock.
- R10: The count acknowledge word at 0x08 has bit 0 for the low-half write and bit 1 for the high-half write. It has the same timing and write-1-to-clear rule as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 6 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Compare interrupt, level |

## Verification
The status bit can be set by a match and cleared by software on the same clock. The compare value can be advanced by a reload and overwritten by the bus on the same clock. The bench provokes both cases by waiting until its own model shows that the count equals the compare value, and then issuing the write on the very next clock. It then reads the status bit back and expects 1, and reads the compare halves back and expects the written low word with an unchanged high word. A clear issued on a later clock, when there is no match, must bring the status bit to 0.

// File: rtl/gtimer64_pkg.sv
package gtimer64_pkg;

    localparam int HALF_W = 32;
    localparam int ADDR_W = 6;
    localparam int GACK_N = 4;   // compare low, compare high, step, control
    localparam int CACK_N = 2;   // count low, count high

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_LO  = 6'h00,
        A_CNT_HI  = 6'h04,
        A_CNT_ACK = 6'h08,
        A_CMP_LO  = 6'h0C,
        A_CMP_HI  = 6'h10,
        A_STEP    = 6'h14,
        A_CTRL    = 6'h18,
        A_IRQ_EN  = 6'h1C,
        A_IRQ_ST  = 6'h20,
        A_ACK     = 6'h24
    } reg_addr_e;

    typedef enum logic {
        CNT_HALT  = 1'b0,
        CNT_COUNT = 1'b1
    } cnt_state_e;

    // bit 0 = compare enable, bit 1 = reload enable
    typedef enum logic [1:0] {
        CMP_OFF    = 2'b00,
        CMP_SINGLE = 2'b01,
        CMP_PARKED = 2'b10,
        CMP_REPEAT = 2'b11
    } cmp_state_e;

endpackage

// File: rtl/gtimer64_ack.sv
module gtimer64_ack #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] upd,
    input  logic [N-1:0] clr,
    output logic [N-1:0] sticky
);

    // per register: the write marks a pending flag, and the flag turns
    // into the sticky bit one clock later; a new acknowledge beats a clear
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic pend_q;
        logic hold_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                pend_q <= upd[i];
                hold_q <= pend_q | (hold_q & ~clr[i]);
            end
        end

        assign sticky[i] = hold_q;
    end

endmodule

// File: rtl/gtimer64_count.sv
module gtimer64_count
    import gtimer64_pkg::*;
#(
    parameter int HALF = HALF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            run_req,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [HALF-1:0] wdata,
    output logic [2*HALF-1:0] count,
    output logic            running
);

    localparam int CNT_W = 2 * HALF;

    cnt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT:  if (ctrl_wr &&  run_req) state_d = CNT_COUNT;
            CNT_COUNT: if (ctrl_wr && !run_req) state_d = CNT_HALT;
            default:   state_d = CNT_HALT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CNT_COUNT: running = 1'b1;
            default:   running = 1'b0;
        endcase
    end

    // a preset write wins over counting on its clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (wr_lo)   count <= {count[CNT_W-1:HALF], wdata};
        else if (wr_hi)   count <= {wdata, count[HALF-1:0]};
        else if (running) count <= count + {{(CNT_W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/gtimer64_cmp.sv
module gtimer64_cmp
    import gtimer64_pkg::*;
#(
    parameter int HALF = HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*HALF-1:0] count,
    input  logic              ctrl_wr,
    input  logic [1:0]        mode_req,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_step,
    input  logic [HALF-1:0]   wdata,
    input  logic              ist_clr,
    output logic [2*HALF-1:0] cmp_val,
    output logic [HALF-1:0]   step_val,
    output logic [1:0]        mode_bits,
    output logic              hit,
    output logic              ist
);

    localparam int CNT_W = 2 * HALF;

    cmp_state_e state_q, state_d;
    logic       armed;
    logic       reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_OFF, CMP_PARKED, CMP_SINGLE, CMP_REPEAT:
                if (ctrl_wr) state_d = cmp_state_e'(mode_req);
            default: state_d = CMP_OFF;
        endcase
    end

    always_comb begin
        armed  = 1'b0;
        reload = 1'b0;
        unique case (state_q)
            CMP_SINGLE: armed = 1'b1;
            CMP_REPEAT: begin
                armed  = 1'b1;
                reload = 1'b1;
            end
            default: ;
        endcase
    end

    assign mode_bits = state_q;
    assign hit       = armed && (count == cmp_val);

    // bus writes beat the reload on the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cmp_val <= '0;
        else if (wr_lo)          cmp_val <= {cmp_val[CNT_W-1:HALF], wdata};
        else if (wr_hi)          cmp_val <= {wdata, cmp_val[HALF-1:0]};
        else if (hit && reload)  cmp_val <= cmp_val + {{HALF{1'b0}}, step_val};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       step_val <= '0;
        else if (wr_step) step_val <= wdata;
    end

    // a match beats a clear on the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ist <= 1'b0;
        else if (hit)     ist <= 1'b1;
        else if (ist_clr) ist <= 1'b0;
    end

endmodule

// File: rtl/gtimer64.sv
module gtimer64
    import gtimer64_pkg::*;
#(
    parameter int HALF = HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF-1:0]   bus_wdata,
    output logic [HALF-1:0]   bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * HALF;

    logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ack;
    logic wr_cmp_lo, wr_cmp_hi, wr_step, wr_ctrl;
    logic wr_ien, wr_ist, wr_ack;

    assign wr_cnt_lo  = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_cnt_hi  = bus_wr && (bus_addr == A_CNT_HI);
    assign wr_cnt_ack = bus_wr && (bus_addr == A_CNT_ACK);
    assign wr_cmp_lo  = bus_wr && (bus_addr == A_CMP_LO);
    assign wr_cmp_hi  = bus_wr && (bus_addr == A_CMP_HI);
    assign wr_step    = bus_wr && (bus_addr == A_STEP);
    assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
    assign wr_ien     = bus_wr && (bus_addr == A_IRQ_EN);
    assign wr_ist     = bus_wr && (bus_addr == A_IRQ_ST);
    assign wr_ack     = bus_wr && (bus_addr == A_ACK);

    logic [CNT_W-1:0] cnt_val;
    logic             cnt_run;
    logic [CNT_W-1:0] cmp_val;
    logic [HALF-1:0]  step_val;
    logic [1:0]       cmp_mode;
    logic             cmp_hit;
    logic             irq_st;
    logic             irq_en;
    logic [GACK_N-1:0] g_ack, g_clr;
    logic [CACK_N-1:0] c_ack, c_clr;

    gtimer64_count #(.HALF(HALF)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_ctrl),
        .run_req (bus_wdata[0]),
        .wr_lo   (wr_cnt_lo),
        .wr_hi   (wr_cnt_hi),
        .wdata   (bus_wdata),
        .count   (cnt_val),
        .running (cnt_run)
    );

    gtimer64_cmp #(.HALF(HALF)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (cnt_val),
        .ctrl_wr   (wr_ctrl),
        .mode_req  (bus_wdata[2:1]),
        .wr_lo     (wr_cmp_lo),
        .wr_hi     (wr_cmp_hi),
        .wr_step   (wr_step),
        .wdata     (bus_wdata),
        .ist_clr   (wr_ist && bus_wdata[0]),
        .cmp_val   (cmp_val),
        .step_val  (step_val),
        .mode_bits (cmp_mode),
        .hit       (cmp_hit),
        .ist       (irq_st)
    );

    assign g_clr = wr_ack ? {bus_wdata[16], bus_wdata[2], bus_wdata[1], bus_wdata[0]}
                          : '0;
    assign c_clr = wr_cnt_ack ? bus_wdata[1:0] : '0;

    gtimer64_ack #(.N(GACK_N)) u_gack (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    ({wr_ctrl, wr_step, wr_cmp_hi, wr_cmp_lo}),
        .clr    (g_clr),
        .sticky (g_ack)
    );

    gtimer64_ack #(.N(CACK_N)) u_cack (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    ({wr_cnt_hi, wr_cnt_lo}),
        .clr    (c_clr),
        .sticky (c_ack)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_en <= 1'b0;
        else if (wr_ien) irq_en <= bus_wdata[0];
    end

    assign irq = irq_st & irq_en;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO:  bus_rdata = cnt_val[HALF-1:0];
            A_CNT_HI:  bus_rdata = cnt_val[CNT_W-1:HALF];
            A_CNT_ACK: bus_rdata[CACK_N-1:0] = c_ack;
            A_CMP_LO:  bus_rdata = cmp_val[HALF-1:0];
            A_CMP_HI:  bus_rdata = cmp_val[CNT_W-1:HALF];
            A_STEP:    bus_rdata = step_val;
            A_CTRL:    bus_rdata[2:0] = {cmp_mode, cnt_run};
            A_IRQ_EN:  bus_rdata[0] = irq_en;
            A_IRQ_ST:  bus_rdata[0] = irq_st;
            A_ACK: begin
                bus_rdata[2:0] = g_ack[2:0];
                bus_rdata[16]  = g_ack[3];
            end
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gtimer64_chk.sv
module gtimer64_chk #(
    parameter int HALF = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2*HALF-1:0] cnt_val,
    input logic              cnt_run,
    input logic              wr_cnt_lo,
    input logic              wr_cnt_hi,
    input logic [2*HALF-1:0] cmp_val,
    input logic [HALF-1:0]   step_val,
    input logic [1:0]        cmp_mode,
    input logic              wr_cmp_lo,
    input logic              wr_cmp_hi,
    input logic              irq_st,
    input logic [3:0]        g_ack,
    input logic [3:0]        g_clr
);

    logic match;
    assign match = cmp_mode[0] && (cnt_val == cmp_val);

    assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_run && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_val));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_run && !wr_cnt_lo && !wr_cnt_hi) |=> cnt_val == $past(cnt_val) + 1);

    assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_st);

    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && cmp_mode[1] && !wr_cmp_lo && !wr_cmp_hi)
        |=> cmp_val == $past(cmp_val) + {{HALF{1'b0}}, $past(step_val)});

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (g_clr == 4'b0) |=> ((g_ack & $past(g_ack)) == $past(g_ack)));

    assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp_lo |=> ##1 g_ack[0]);

endmodule

bind gtimer64 gtimer64_chk #(.HALF(HALF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .cnt_run   (cnt_run),
    .wr_cnt_lo (wr_cnt_lo),
    .wr_cnt_hi (wr_cnt_hi),
    .cmp_val   (cmp_val),
    .step_val  (step_val),
    .cmp_mode  (cmp_mode),
    .wr_cmp_lo (wr_cmp_lo),
    .wr_cmp_hi (wr_cmp_hi),
    .irq_st    (irq_st),
    .g_ack     (g_ack),
    .g_clr     (g_clr)
);

// File: tb/test_gtimer64.sv
module test_gtimer64;
    import gtimer64_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;   // 4 ns period

    gtimer64 i_gtimer64 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    int     n_chk = 0;
    int     n_err = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    // behavioural reference model
    logic [63:0] m_cnt = '0, m_cmp = '0;
    logic [31:0] m_step = '0;
    bit m_run, m_en, m_auto, m_ien, m_ist;
    bit [3:0] m_gp, m_gs;
    bit [1:0] m_cp, m_cs;

    logic [63:0] last_m;
    logic        last_irq;

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return m_cnt[31:0];
            6'h04: return m_cnt[63:32];
            6'h08: return {30'h0, m_cs};
            6'h0C: return m_cmp[31:0];
            6'h10: return m_cmp[63:32];
            6'h14: return m_step;
            6'h18: return {29'h0, m_auto, m_en, m_run};
            6'h1C: return {31'h0, m_ien};
            6'h20: return {31'h0, m_ist};
            6'h24: return {15'h0, m_gs[3], 13'h0, m_gs[2:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] a);
        case (a)
            6'h00, 6'h04: return "R2";
            6'h08:        return "R10";
            6'h0C, 6'h10, 6'h14: return "R8";
            6'h1C:        return "R6";
            6'h20:        return "R5";
            6'h24:        return "R9";
            default:      return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        logic        hit;
        logic [63:0] ncnt, ncmp;
        bit [3:0]    gclr;
        bit [1:0]    cclr;
        cyc++;
        if (!rst_n) begin
            m_cnt = '0; m_cmp = '0; m_step = '0;
            m_run = 0; m_en = 0; m_auto = 0; m_ien = 0; m_ist = 0;
            m_gp = 0; m_gs = 0; m_cp = 0; m_cs = 0;
        end else begin
            hit  = m_en && (m_cnt == m_cmp);
            ncnt = m_run ? m_cnt + 64'd1 : m_cnt;
            ncmp = (hit && m_auto) ? m_cmp + {32'h0, m_step} : m_cmp;
            gclr = 0; cclr = 0;
            if (hit) m_ist = 1;
            m_gs = (m_gs & ~gclr) | m_gp;
            m_cs = (m_cs & ~cclr) | m_cp;
            m_gp = 0; m_cp = 0;
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: begin ncnt = {m_cnt[63:32], bus_wdata}; m_cp[0] = 1; end
                    6'h04: begin ncnt = {bus_wdata, m_cnt[31:0]}; m_cp[1] = 1; end
                    6'h08: m_cs = m_cs & ~bus_wdata[1:0];
                    6'h0C: begin ncmp = {m_cmp[63:32], bus_wdata}; m_gp[0] = 1; end
                    6'h10: begin ncmp = {bus_wdata, m_cmp[31:0]}; m_gp[1] = 1; end
                    6'h14: begin m_step = bus_wdata; m_gp[2] = 1; end
                    6'h18: begin
                        m_run = bus_wdata[0]; m_en = bus_wdata[1];
                        m_auto = bus_wdata[2]; m_gp[3] = 1;
                    end
                    6'h1C: m_ien = bus_wdata[0];
                    6'h20: if (bus_wdata[0] && !hit) m_ist = 0;
                    6'h24: m_gs = m_gs & ~{bus_wdata[16], bus_wdata[2:0]};
                    default: ;
                endcase
            end
            // a fresh acknowledge from the previous clock survives a clear
            m_gs = m_gs | (m_gs_prev_pend);
            m_cs = m_cs | (m_cs_prev_pend);
            m_cnt = ncnt;
            m_cmp = ncmp;
        end
    end

    // pending flags as they stood before the edge (sticky takes these)
    bit [3:0] m_gs_prev_pend = 0;
    bit [1:0] m_cs_prev_pend = 0;
    always @(negedge clk) begin
        m_gs_prev_pend = m_gp;
        m_cs_prev_pend = m_cp;
    end

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_of(bus_addr), {32'h0, bus_rdata}, {32'h0, m_read(bus_addr)});
            chk("R6", {63'h0, irq}, {63'h0, (m_ist & m_ien)});
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata; last_m = m_cnt; last_irq = irq;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_irq(output longint t, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
        t = cyc;
        @(posedge clk); #1;
    endtask

    task automatic wait_match();
        for (int k = 0; k < 40; k++) begin
            if (m_cnt == m_cmp) break;
            idle(1);
        end
    endtask

    task automatic rd64(output logic [63:0] v, output logic [63:0] snap, output int tries);
        logic [31:0] h1, lo, h2;
        tries = 0;
        rd(6'h04, h1);
        for (int k = 0; k < 8; k++) begin
            rd(6'h00, lo);
            snap = last_m;
            rd(6'h04, h2);
            if (h1 == h2) break;
            h1 = h2;
            tries++;
        end
        v = {h2, lo};
    endtask

    initial begin
        logic [31:0] v;
        logic [63:0] v64, snap;
        int          tries;
        longint      t1, t2;
        bit          seen;
        logic [31:0] hi_keep;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(6'h00, v); chk("R1", v, 0);
        rd(6'h18, v); chk("R1", v, 0);
        rd(6'h24, v); chk("R1", v, 0);
        rd(6'h20, v); chk("R1", v, 0);
        chk("R1", last_irq, 0);

        // R2: halted count holds
        idle(3);
        rd(6'h00, v); chk("R2", v, 0);

        // R3 / R10: preset both halves, then acknowledge timing and clearing
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h08, v); chk("R10", v, 0);
        wr(6'h04, 32'h0000_0005);
        idle(1);
        rd(6'h08, v); chk("R10", v, 3);
        rd(6'h00, v); chk("R3", v, 32'hFFFF_FFFF);
        wr(6'h08, 32'h1);
        rd(6'h08, v); chk("R10", v, 2);
        wr(6'h08, 32'h2);
        rd(6'h08, v); chk("R10", v, 0);

        // R2: start and read across a low-to-high carry
        wr(6'h18, 32'h1);
        rd64(v64, snap, tries);
        chk("R2", v64, snap);
        chk("R2", tries, 1);
        chk("R2", v64[63:32], 6);

        // R3: write during counting takes effect without an increment
        wr(6'h00, 32'd100);
        rd(6'h00, v); chk("R3", v, 100);
        rd(6'h00, v); chk("R2", v, 101);

        // R9: acknowledge appears one clock after the register changes
        wr(6'h24, 32'h0001_0007);
        wr(6'h0C, 32'h0000_0000);
        rd(6'h24, v); chk("R9", v[0], 0);
        rd(6'h24, v); chk("R9", v[0], 1);
        wr(6'h24, 32'h0001_0007);
        rd(6'h24, v); chk("R9", v, 0);
        // R9: fresh acknowledge beats clear on the same clock
        wr(6'h14, 32'd10);
        wr(6'h24, 32'h4);
        rd(6'h24, v); chk("R9", v[2], 1);

        // R4: control readback, compare parked
        wr(6'h18, 32'h5);
        rd(6'h18, v); chk("R4", v, 5);
        rd(6'h24, v); chk("R9", v[16], 1);

        // R5 / R6: single match
        wr(6'h1C, 32'h1);
        wr(6'h10, m_cnt[63:32]);
        wr(6'h0C, m_cnt[31:0] + 32'd20);
        wr(6'h18, 32'h3);
        wait_irq(t1, seen);
        chk("R5", seen, 1);
        rd(6'h20, v); chk("R5", v, 1);
        wr(6'h1C, 32'h0);
        rd(6'h20, v); chk("R6", last_irq, 0);
        chk("R6", v, 1);
        wr(6'h1C, 32'h1);
        wr(6'h20, 32'h1);
        rd(6'h20, v); chk("R7", v, 0);
        chk("R6", last_irq, 0);

        // R8: periodic reload with step 10
        wr(6'h0C, m_cnt[31:0] + 32'd12);
        wr(6'h18, 32'h7);
        wait_irq(t1, seen);
        chk("R8", seen, 1);
        wr(6'h20, 32'h1);
        wait_irq(t2, seen);
        chk("R8", seen, 1);
        chk("R8", t2 - t1, 10);

        // R7: clear on the match clock leaves status set
        wait_match();
        wr(6'h20, 32'h1);
        rd(6'h20, v); chk("R7", v, 1);
        wr(6'h20, 32'h1);
        rd(6'h20, v); chk("R7", v, 0);

        // R8: compare write on the match clock wins over reload
        wait_match();
        hi_keep = m_cmp[63:32];
        wr(6'h0C, 32'h0000_0005);
        rd(6'h0C, v); chk("R8", v, 5);
        rd(6'h10, v); chk("R8", v, hi_keep);

        // R2: stop and hold
        wr(6'h18, 32'h0);
        rd(6'h00, v);
        idle(3);
        rd(6'h00, v64[31:0]); chk("R2", v64[31:0], v);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule